// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Controller

This block is the feedback divider of a frequency synthesizer loop. It runs on the output clock of an external dual-modulus prescaler, and it drives the prescaler's modulus-select line and its ratio-pair select. Two counters work together. A swallow count A keeps the prescaler on its larger modulus P+1. A main count B sets how many prescaler output cycles make up one feedback period. Together they divide the oscillator frequency by N = P·B + A, where P is the smaller modulus of the selected pair.

Each feedback period starts with a reload. Both counters take the programmed A and B, and the pair select is captured at the same moment. The modulus line stays high for A prescaler cycles and then low for the remaining B−A cycles. On the last cycle the block raises a one-cycle feedback pulse for the phase detector. Programming changes are sampled only at a reload, so a period that is already running always completes with its old setting. A power-down input silences the outputs and holds the counters in their reload state. The first edge after power-down is released starts a fresh period.

With the defaults, the block fits the high-frequency loop: a 7-bit A with pairs 64/65 or 128/129. With `A_W = 4`, it fits the low-frequency loop: A up to 15 with pairs 8/9 or 16/17.

Top module: `swallow_div`

## Requirements
- R1: While `rst_n` is low, `fb_pulse`, `mod_hi` and `pre_q` are all 0.
- R2: In steady state, the time between rising edges of `fb_pulse` equals P·B + A oscillator cycles. P is the smaller modulus of the pair named by `pre_q`: 0 selects the smaller pair (8/9 for `A_W = 4`) and 1 selects the larger pair (16/17).
- R3: `fb_pulse` is high for exactly one prescaler-output cycle, and it rises once every B prescaler-output cycles.
- R4: After each reload, `mod_hi` is high for exactly the first A prescaler-output cycles of the period and low for the rest. With A = 0 it never goes high.
- R5: The full legal range B = 3 to 2^B_W−1 and A = 0 to 2^A_W−1 with A ≤ B is supported, including the edge case A = B, where `mod_hi` stays high through the terminal cycle.
- R6: New `a_val`, `b_val` and `pre_sel` values are used only at the reload that follows a terminal cycle. The running period keeps its old length, and `pre_q` changes only at a reload.
- R7: While `pd` is high, `fb_pulse` and `mod_hi` stay 0 and `pre_q` holds its value. After `pd` falls, the block reloads on the first edge and then produces correct periods again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd | input | 1 | Power-down: silences the outputs and holds the counters at reload |
| a_val | input | A_W | Swallow count A |
| b_val | input | B_W | Main count B (3 or more) |
| pre_sel | input | 1 | Ratio-pair select, 0 = smaller pair |
| mod_hi | output | 1 | Modulus select to the prescaler, 1 = divide by P+1 |
| fb_pulse | output | 1 | One-cycle feedback pulse to the phase detector |
| pre_q | output | 1 | Ratio-pair select captured at the last reload |

## Verification
Two events can land in the same cycle: a write of new A, B or pair values, and the terminal-count reload that consumes them. A second case is the last swallowed cycle falling on the terminal cycle when A = B. The bench changes the settings a few cycles into a running period and also sweeps every A from 0 up to B. The bench models the prescaler itself, dividing a 200 MHz oscillator by P or P+1 according to `mod_hi`. It then checks three things against the arithmetic P·B + A: the oscillator cycles per feedback period, the prescaler cycles per period, and how many of those cycles had `mod_hi` high. It also checks that the period in progress at the write keeps its old length and that `pre_q` moves only after the next pulse.

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input  logic           pclk,
  input  logic           rst_n,
  input  logic           pd,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic           pre_sel,
  output logic           mod_hi,
  output logic           fb_pulse,
  output logic           pre_q
);

  logic [B_W-1:0] b_cnt;
  logic [A_W-1:0] a_cnt;
  logic           live;
  logic           reload;

  assign reload = (b_cnt == '0);

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt <= '0;
      a_cnt <= '0;
      live  <= 1'b0;
      pre_q <= 1'b0;
    end else if (pd) begin
      b_cnt <= '0;
      a_cnt <= '0;
      live  <= 1'b0;
    end else begin
      live <= 1'b1;
      if (reload) begin
        b_cnt <= b_val - 1'b1;
        a_cnt <= a_val;
        pre_q <= pre_sel;
      end else begin
        b_cnt <= b_cnt - 1'b1;
        if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
      end
    end
  end

  assign mod_hi   = (a_cnt != '0);
  assign fb_pulse = live & reload;

endmodule

module swallow_div_chk #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input logic           pclk,
  input logic           rst_n,
  input logic           pd,
  input logic [B_W-1:0] b_val,
  input logic [B_W-1:0] b_cnt,
  input logic           mod_hi,
  input logic           fb_pulse,
  input logic           pre_q
);

  a_r7_pd_silences: assert property (@(posedge pclk) disable iff (!rst_n)
    pd |=> (!fb_pulse && !mod_hi));

  a_r3_single_pulse: assert property (@(posedge pclk) disable iff (!rst_n)
    (fb_pulse && b_val >= B_W'(3)) |=> !fb_pulse);

  a_r6_pre_at_reload: assert property (@(posedge pclk) disable iff (!rst_n)
    (pre_q != $past(pre_q)) |-> $past(b_cnt == '0));

  a_r4_mod_stays_low: assert property (@(posedge pclk) disable iff (!rst_n)
    (!mod_hi && b_cnt != '0) |=> !mod_hi);

endmodule

bind swallow_div swallow_div_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .pclk(pclk), .rst_n(rst_n), .pd(pd), .b_val(b_val), .b_cnt(b_cnt),
  .mod_hi(mod_hi), .fb_pulse(fb_pulse), .pre_q(pre_q)
);

// File: tb/swallow_div_test.sv
module swallow_div_test;
  localparam int AW = 4;
  localparam int BW = 11;

  logic vco = 1'b0;
  logic rst_n = 1'b0;
  logic pclk;
  logic pd = 1'b0;
  logic [AW-1:0] a_val = '0;
  logic [BW-1:0] b_val = BW'(3);
  logic pre_sel = 1'b0;
  logic mod_hi, fb_pulse, pre_q;

  int n_cmp = 0, n_bad = 0;
  int tick = 0;
  int pcnt, div;

  always #2.5 vco = ~vco;

  swallow_div #(.A_W(AW), .B_W(BW)) uut (
    .pclk(pclk), .rst_n(rst_n), .pd(pd), .a_val(a_val), .b_val(b_val),
    .pre_sel(pre_sel), .mod_hi(mod_hi), .fb_pulse(fb_pulse), .pre_q(pre_q)
  );

  // behavioural dual-modulus prescaler: P = 8 or 16, plus one when mod_hi
  always @(posedge vco or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= 0; div <= 8; pclk <= 1'b0;
    end else begin
      if (pcnt == div - 1) begin
        pcnt <= 0;
        div  <= (pre_q ? 16 : 8) + (mod_hi ? 1 : 0);
      end else pcnt <= pcnt + 1;
      pclk <= (pcnt == div - 1);
    end
  end

  always @(posedge vco) tick <= tick + 1;

  int ev_n = 0, ev_tick = 0, ev_per = 0, ev_hi = 0, ev_pc = 0, ev_w = 0;
  int mcnt = 0, pc = 0, wlen = 0;
  logic fb_d = 1'b0;

  always @(negedge pclk) begin
    mcnt = mcnt + (mod_hi ? 1 : 0);
    pc = pc + 1;
    if (fb_pulse) wlen = wlen + 1;
    else if (fb_d) begin ev_w = wlen; wlen = 0; end
    if (fb_pulse && !fb_d) begin
      ev_per = tick - ev_tick; ev_tick = tick;
      ev_hi = mcnt; mcnt = 0;
      ev_pc = pc; pc = 0;
      ev_n = ev_n + 1;
    end
    fb_d = fb_pulse;
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ev(int n);
    int s = ev_n;
    while (ev_n < s + n) @(negedge vco);
  endtask

  task automatic set_cfg(int a, int b, int pr);
    @(negedge pclk);
    a_val = AW'(a); b_val = BW'(b); pre_sel = pr[0];
  endtask

  task automatic run_cfg(int a, int b, int pr);
    int p = pr ? 16 : 8;
    set_cfg(a, b, pr);
    wait_ev(3);
    chk("R2 period", ev_per, p * b + a);
    chk("R3 pulse spacing", ev_pc, b);
    if (a == 0) chk("R4 zero swallow", ev_hi, 0);
    else if (a == b) chk("R5 A equals B", ev_hi, a);
    else chk("R4 swallow count", ev_hi, a);
    wait_ev(1);
    chk("R3 pulse width", ev_w, 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge vco) if (tick > 190000) begin
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d", tick, 190000);
    finish_run();
  end

  initial begin
    repeat (20) @(negedge vco);
    chk("R1 reset fb", int'(fb_pulse), 0);
    chk("R1 reset mod", int'(mod_hi), 0);
    chk("R1 reset pre", int'(pre_q), 0);
    rst_n = 1'b1;

    for (int pr = 0; pr < 2; pr++)
      for (int b = 3; b <= 9; b++)
        for (int a = 0; a <= b; a++)
          run_cfg(a, b, pr);
    run_cfg(15, 100, 1);
    run_cfg(15, 15, 0);

    // R6: change settings a few cycles into a running period
    run_cfg(2, 9, 0);
    wait_ev(1);
    repeat (3) @(negedge pclk);
    a_val = AW'(5); b_val = BW'(6); pre_sel = 1'b1;
    @(negedge pclk);
    chk("R6 pre held mid-period", int'(pre_q), 0);
    wait_ev(1);
    chk("R6 old period kept", ev_per, 8 * 9 + 2);
    chk("R6 old swallow kept", ev_hi, 2);
    chk("R6 old spacing kept", ev_pc, 9);
    wait_ev(2);
    chk("R6 new period", ev_per, 16 * 6 + 5);
    chk("R6 new swallow", ev_hi, 5);
    chk("R6 pre updated", int'(pre_q), 1);

    // R7: power-down
    @(negedge pclk);
    pd = 1'b1;
    pre_sel = 1'b0; a_val = AW'(3); b_val = BW'(7);
    @(negedge pclk);
    begin
      int fb_seen = 0, mod_seen = 0, pre_moved = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge pclk);
        fb_seen += fb_pulse ? 1 : 0;
        mod_seen += mod_hi ? 1 : 0;
        pre_moved += (pre_q != 1'b1) ? 1 : 0;
      end
      chk("R7 no pulse in power-down", fb_seen, 0);
      chk("R7 no modulus in power-down", mod_seen, 0);
      chk("R7 pre held in power-down", pre_moved, 0);
    end
    pd = 1'b0;
    wait_ev(3);
    chk("R7 period after wake", ev_per, 8 * 7 + 3);
    chk("R7 swallow after wake", ev_hi, 3);
    chk("R7 pre after wake", int'(pre_q), 0);

    finish_run();
  end
endmodule